// File: doc/BRIEF.md
# Reciprocal Square Root Seed Generator

This block turns an IEEE 754 single-precision operand into a rough first guess of 1/sqrt(x). Software then sharpens that guess with a few refinement iterations. Each operand is presented with a one-cycle strobe, and the block returns a 32-bit seed word one clock later, along with two status bits.

The operand is first sorted into exactly one class, with the checks taken in a fixed priority. NaN wins over everything. Zero or denormal comes next, then a negative sign, then positive infinity. Only a positive normal number reaches the arithmetic path. On that path the output exponent comes from a subtraction and a shift of the input exponent. The 8-bit output significand is read from a 128-entry constant ROM. The ROM index is the parity of the decremented exponent, joined to the six leading fraction bits. Invalid operations raise a sticky invalid flag and a per-operation summary flag.

Top module: `rsqrt_seed`

## Requirements
- R1: When the exponent field is all ones and the fraction is nonzero (a NaN), the result is the quiet NaN 0x7FC00000, whatever the sign. This check comes before every other class.
- R2: When the exponent field is zero (zero or denormal), the result is an infinity that carries the input sign: 0x7F800000 for positive, 0xFF800000 for negative.
- R3: When the sign bit is 1 and the input is neither a NaN nor zero/denormal (negative normal or negative infinity), the result is the square-root NaN code 0x7FC00004.
- R4: Positive infinity (0x7F800000) gives +0 (0x00000000).
- R5: For a positive normal input with exponent field E, the result has sign 0 and exponent field 0xBD minus ((E-1) shifted right by one). Its bits [14:0] are zero.
- R6: For a positive normal input, result bits [22:15] come from a 128-entry table. The table index is ((E-1) bit 0) in index bit 6 and input bits [22:17] in index bits [5:0]. Input bits [16:0] have no effect. Table entries fall from 253 at index 0 to 2 at index 127. Each odd index holds one less than the even index just below it.
- R7: An operation sets both the invalid bit and the summary bit when its input is a signaling NaN or its result is 0x7FC00004. A signaling NaN has an all-ones exponent, a nonzero fraction and fraction bit 22 equal to 0. Any other operation clears the summary bit and leaves the invalid bit unchanged. Only reset clears the invalid bit.
- R8: Result, status and out_valid change one clock after a cycle with in_valid high. out_valid is high for exactly one cycle per strobe. In cycles without a strobe, the result and status hold.
- R9: Synchronous reset drives out_valid, the result and both status bits to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe |
| in_op | input | 32 | Single-precision operand |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_result | output | 32 | Seed word or special-case code |
| out_invalid | output | 1 | Sticky invalid-operation flag |
| out_summary | output | 1 | Invalid indication of the latest operation |

## Verification
The hardest situation to reach is an exhaustive sweep of the seed table. Every one of the 128 indices needs its own operand, and index bit 6 can only be set through the exponent's parity. The stimulus therefore builds one operand per index: it picks an exponent whose decremented value has the right parity, varies the exponent across its range, and fills the ignored low fraction bits with a changing pattern. The sticky invalid bit also takes care to check: a signaling NaN is followed by clean operations, and the bench confirms that the summary bit clears while the invalid bit stays set until reset.

// File: rtl/rsqrt_seed_pkg.sv
package rsqrt_seed_pkg;

  // Operand class, in order of screening priority.
  typedef enum logic [2:0] {
    CLS_NAN  = 3'd0,
    CLS_ZERO = 3'd1,
    CLS_NEG  = 3'd2,
    CLS_PINF = 3'd3,
    CLS_NORM = 3'd4
  } op_class_e;

  // Even-index seed values. Each odd index is the value below it minus one.
  function automatic logic [7:0] seed_pair_lead(input int unsigned k);
    logic [7:0] v;
    case (k)
      0: v = 8'd253;  1: v = 8'd245;  2: v = 8'd239;  3: v = 8'd231;
      4: v = 8'd225;  5: v = 8'd217;  6: v = 8'd211;  7: v = 8'd205;
      8: v = 8'd201;  9: v = 8'd195; 10: v = 8'd189; 11: v = 8'd185;
     12: v = 8'd179; 13: v = 8'd175; 14: v = 8'd169; 15: v = 8'd165;
     16: v = 8'd161; 17: v = 8'd157; 18: v = 8'd153; 19: v = 8'd149;
     20: v = 8'd145; 21: v = 8'd141; 22: v = 8'd137; 23: v = 8'd133;
     24: v = 8'd131; 25: v = 8'd127; 26: v = 8'd123; 27: v = 8'd121;
     28: v = 8'd117; 29: v = 8'd115; 30: v = 8'd111; 31: v = 8'd109;
     32: v = 8'd103; 33: v = 8'd99;  34: v = 8'd93;  35: v = 8'd89;
     36: v = 8'd83;  37: v = 8'd79;  38: v = 8'd75;  39: v = 8'd71;
     40: v = 8'd67;  41: v = 8'd63;  42: v = 8'd59;  43: v = 8'd55;
     44: v = 8'd53;  45: v = 8'd49;  46: v = 8'd45;  47: v = 8'd43;
     48: v = 8'd39;  49: v = 8'd37;  50: v = 8'd33;  51: v = 8'd31;
     52: v = 8'd27;  53: v = 8'd25;  54: v = 8'd23;  55: v = 8'd19;
     56: v = 8'd17;  57: v = 8'd15;  58: v = 8'd13;  59: v = 8'd11;
     60: v = 8'd9;   61: v = 8'd7;   62: v = 8'd5;   63: v = 8'd3;
      default: v = 8'd0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/rsqrt_seed_classify.sv
module rsqrt_seed_classify
  import rsqrt_seed_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic [WORD_W-1:0] op_i,
  output op_class_e         cls_o,
  output logic              snan_o
);

  logic              sign;
  logic [EXP_W-1:0]  expo;
  logic [FRAC_W-1:0] frac;
  logic              exp_ones, exp_zero, frac_nz, is_nan;

  assign sign     = op_i[WORD_W-1];
  assign expo     = op_i[WORD_W-2 -: EXP_W];
  assign frac     = op_i[FRAC_W-1:0];
  assign exp_ones = &expo;
  assign exp_zero = ~|expo;
  assign frac_nz  = |frac;
  assign is_nan   = exp_ones & frac_nz;
  assign snan_o   = is_nan & ~frac[FRAC_W-1];

  always_comb begin
    if (is_nan)        cls_o = CLS_NAN;
    else if (exp_zero) cls_o = CLS_ZERO;
    else if (sign)     cls_o = CLS_NEG;
    else if (exp_ones) cls_o = CLS_PINF;
    else               cls_o = CLS_NORM;
  end

endmodule

// File: rtl/rsqrt_seed_rom.sv
module rsqrt_seed_rom
  import rsqrt_seed_pkg::*;
#(
  parameter int IDX_W  = 7,
  parameter int SEED_W = 8,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic [IDX_W-1:0]  idx_i,
  output logic [SEED_W-1:0] seed_o
);

  logic [SEED_W-1:0] rom [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    localparam logic [7:0] LEAD = seed_pair_lead(g / 2);
    localparam logic [7:0] VAL  = LEAD - 8'(g % 2);
    assign rom[g] = SEED_W'(VAL);
  end

  assign seed_o = rom[idx_i];

endmodule

// File: rtl/rsqrt_seed_normal.sv
module rsqrt_seed_normal #(
  parameter int EXP_W        = 8,
  parameter int FRAC_W       = 23,
  parameter int IDX_M        = 6,
  parameter int SEED_W       = 8,
  parameter int OUT_EXP_BASE = 189,
  localparam int WORD_W = 1 + EXP_W + FRAC_W,
  localparam int IDX_W  = IDX_M + 1,
  localparam int PAD_W  = FRAC_W - SEED_W
) (
  input  logic [WORD_W-1:0] op_i,
  output logic [WORD_W-1:0] word_o
);

  logic [EXP_W-1:0]  em1;
  logic [EXP_W-1:0]  new_exp;
  logic [IDX_W-1:0]  idx;
  logic [SEED_W-1:0] seed;

  assign em1     = op_i[WORD_W-2 -: EXP_W] - EXP_W'(1);
  assign idx     = {em1[0], op_i[FRAC_W-1 -: IDX_M]};
  assign new_exp = EXP_W'(OUT_EXP_BASE) - (em1 >> 1);

  rsqrt_seed_rom #(
    .IDX_W (IDX_W),
    .SEED_W(SEED_W)
  ) u_rom (
    .idx_i (idx),
    .seed_o(seed)
  );

  assign word_o = {op_i[WORD_W-1], new_exp, seed, {PAD_W{1'b0}}};

endmodule

// File: rtl/rsqrt_seed.sv
module rsqrt_seed
  import rsqrt_seed_pkg::*;
#(
  parameter int EXP_W        = 8,
  parameter int FRAC_W       = 23,
  parameter int IDX_M        = 6,
  parameter int SEED_W       = 8,
  parameter int OUT_EXP_BASE = 189,
  parameter int SQRT_NAN_TAG = 4,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_op,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_result,
  output logic              out_invalid,
  output logic              out_summary
);

  localparam logic [WORD_W-1:0] QNAN_W =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic [WORD_W-1:0] SQNAN_W = QNAN_W | WORD_W'(SQRT_NAN_TAG);

  op_class_e         cls;
  logic              snan;
  logic [WORD_W-1:0] norm_word;
  logic [WORD_W-1:0] next_word;
  logic              raise;

  rsqrt_seed_classify #(
    .EXP_W (EXP_W),
    .FRAC_W(FRAC_W)
  ) u_cls (
    .op_i  (in_op),
    .cls_o (cls),
    .snan_o(snan)
  );

  rsqrt_seed_normal #(
    .EXP_W       (EXP_W),
    .FRAC_W      (FRAC_W),
    .IDX_M       (IDX_M),
    .SEED_W      (SEED_W),
    .OUT_EXP_BASE(OUT_EXP_BASE)
  ) u_norm (
    .op_i  (in_op),
    .word_o(norm_word)
  );

  always_comb begin
    case (cls)
      CLS_NAN:  next_word = QNAN_W;
      CLS_ZERO: next_word = {in_op[WORD_W-1], {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      CLS_NEG:  next_word = SQNAN_W;
      CLS_PINF: next_word = '0;
      default:  next_word = norm_word;
    endcase
  end

  assign raise = snan | (cls == CLS_NEG);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_invalid <= 1'b0;
      out_summary <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result  <= next_word;
        out_summary <= raise;
        if (raise) out_invalid <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/rsqrt_seed_chk.sv
module rsqrt_seed_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [WORD_W-1:0] in_op,
  input logic              out_valid,
  input logic [WORD_W-1:0] out_result,
  input logic              out_invalid,
  input logic              out_summary
);

  localparam logic [WORD_W-1:0] QNAN_C =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic [WORD_W-1:0] SQNAN_C = QNAN_C | WORD_W'(4);
  localparam logic [WORD_W-1:0] PINF_C  = {1'b0, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};

  logic [EXP_W-1:0] e_in;
  logic             f_nz, sgn;
  assign e_in = in_op[WORD_W-2 -: EXP_W];
  assign f_nz = |in_op[FRAC_W-1:0];
  assign sgn  = in_op[WORD_W-1];

  // R8
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_result) && $stable(out_summary)));

  // R1
  nan_out_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (&e_in) && f_nz) |=> out_result == QNAN_C);

  // R2
  zero_inf_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && e_in == '0) |=>
      out_result == (PINF_C | {$past(sgn), {(WORD_W-1){1'b0}}}));

  // R3
  neg_sqnan_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sgn && e_in != '0 && !((&e_in) && f_nz)) |=>
      (out_result == SQNAN_C && out_invalid && out_summary));

  // R4
  pinf_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == PINF_C) |=> out_result == '0);

  // R5
  norm_shape_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !sgn && e_in != '0 && !(&e_in)) |=>
      (!out_result[WORD_W-1] && out_result[FRAC_W-9:0] == '0));

  // R7
  invalid_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    out_invalid |=> out_invalid);

endmodule

bind rsqrt_seed rsqrt_seed_chk #(
  .EXP_W (EXP_W),
  .FRAC_W(FRAC_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_op      (in_op),
  .out_valid  (out_valid),
  .out_result (out_result),
  .out_invalid(out_invalid),
  .out_summary(out_summary)
);

// File: tb/rsqrt_seed_test.sv
module rsqrt_seed_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_op = '0;
  logic        out_valid;
  logic [31:0] out_result;
  logic        out_invalid;
  logic        out_summary;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  rsqrt_seed uut (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_op      (in_op),
    .out_valid  (out_valid),
    .out_result (out_result),
    .out_invalid(out_invalid),
    .out_summary(out_summary)
  );

  // Odd-index seeds; the even index just below is one higher.
  localparam logic [7:0] ODD_SEED [64] = '{
    252, 244, 238, 230, 224, 216, 210, 204, 200, 194, 188, 184,
    178, 174, 168, 164, 160, 156, 152, 148, 144, 140, 136, 132,
    130, 126, 122, 120, 116, 114, 110, 108, 102,  98,  92,  88,
     82,  78,  74,  70,  66,  62,  58,  54,  52,  48,  44,  42,
     38,  36,  32,  30,  26,  24,  22,  18,  16,  14,  12,  10,
      8,   6,   4,   2};

  function automatic logic [7:0] ref_seed(input int i);
    return ODD_SEED[i/2] + ((i % 2 == 0) ? 8'd1 : 8'd0);
  endfunction

  // {operand, expected result, expected summary}
  localparam int NV = 15;
  localparam logic [64:0] VEC [NV] = '{
    {32'h7FC00000, 32'h7FC00000, 1'b0},  // R1 quiet NaN
    {32'h7F800001, 32'h7FC00000, 1'b1},  // R1 R7 signaling NaN
    {32'hFFC00001, 32'h7FC00000, 1'b0},  // R1 negative quiet NaN
    {32'h00000000, 32'h7F800000, 1'b0},  // R2 +0
    {32'h80000000, 32'hFF800000, 1'b0},  // R2 -0
    {32'h00000001, 32'h7F800000, 1'b0},  // R2 denormal
    {32'h807FFFFF, 32'hFF800000, 1'b0},  // R2 negative denormal
    {32'hBF800000, 32'h7FC00004, 1'b1},  // R3 -1.0
    {32'hFF800000, 32'h7FC00004, 1'b1},  // R3 -inf
    {32'h7F800000, 32'h00000000, 1'b0},  // R4 +inf
    {32'h3F800000, 32'h3F7E8000, 1'b0},  // R5 1.0
    {32'h40800000, 32'h3EFE8000, 1'b0},  // R5 4.0
    {32'h40000000, 32'h3F338000, 1'b0},  // R6 2.0, odd parity
    {32'h00800000, 32'h5EFE8000, 1'b0},  // R5 smallest normal
    {32'h7F7FFFFF, 32'h1F810000, 1'b0}   // R6 largest normal, index 127
  };

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] op);
    @(negedge clk);
    in_valid = 1'b1;
    in_op    = op;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %08h expected %08h", 32'h0, 32'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] want;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check(out_valid == 1'b0 && out_result == '0, "R9",
          {31'h0, out_valid} | out_result, 32'h0);
    check(out_invalid == 1'b0 && out_summary == 1'b0, "R9",
          {30'h0, out_invalid, out_summary}, 32'h0);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      apply(VEC[v][64:33]);
      check(out_valid == 1'b1, "R8", {31'h0, out_valid}, 32'h1);
      check(out_result == VEC[v][32:1], "R1-vec", out_result, VEC[v][32:1]);
      check(out_summary == VEC[v][0], "R7", {31'h0, out_summary}, {31'h0, VEC[v][0]});
    end

    // R7: invalid remained set after the clean vectors at the end of the table
    check(out_invalid == 1'b1, "R7", {31'h0, out_invalid}, 32'h1);

    // R6 R5: sweep every table index
    for (int i = 0; i < 128; i++) begin
      logic [7:0]  e;
      logic [7:0]  ne;
      logic [31:0] op;
      e    = 8'((i / 64) + 1 + 2 * (i % 64));
      ne   = 8'(189 - ((e - 8'd1) >> 1));
      op   = {1'b0, e, 6'(i % 64), 17'((i * 977) % 131072)};
      want = {1'b0, ne, ref_seed(i), 15'h0};
      apply(op);
      check(out_result == want, "R6", out_result, want);
    end

    // R8: no strobe, result and status hold
    @(negedge clk);
    in_op = 32'hBF800000;
    @(negedge clk);
    check(out_valid == 1'b0 && out_result == want, "R8", out_result, want);
    check(out_summary == 1'b0, "R8", {31'h0, out_summary}, 32'h0);

    // R8 back-to-back strobes
    @(negedge clk);
    in_valid = 1'b1; in_op = 32'h3F800000;
    @(negedge clk);
    check(out_valid && out_result == 32'h3F7E8000, "R8", out_result, 32'h3F7E8000);
    in_op = 32'h7F800000;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_result == 32'h00000000, "R8", out_result, 32'h0);
    @(negedge clk);
    check(out_valid == 1'b0, "R8", {31'h0, out_valid}, 32'h0);

    // R9: reset clears the sticky invalid bit
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(out_invalid == 1'b0 && out_result == '0, "R9",
          {31'h0, out_invalid} | out_result, 32'h0);

    // R7: invalid sticks over a clean op, summary clears
    apply(32'h7FA00000);
    check(out_invalid && out_summary, "R7",
          {30'h0, out_invalid, out_summary}, 32'h3);
    apply(32'h3F800000);
    check(out_invalid && !out_summary, "R7",
          {30'h0, out_invalid, out_summary}, 32'h2);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule